// File: doc/BRIEF.md
# Two-Word Lockable I/O Port

This block is a small I/O port shared by several requesters inside a core. It holds two 16-bit data words, a one-bit word pointer that selects which word an access uses, and a status bit that the two sides use to signal each other. A requester must own the port through an exclusive lock before it may load from or store to it. The lock is held until the owner releases it. A requester that asks while another one holds the port simply waits.

Every load or store carries a three-bit mode. The condition bit makes the access depend on the status bit. The side-effect bit changes the status bit after the access. The toggle bit flips the word pointer after the access. Each accepted access answers one cycle later. The answer carries the read data, a flag that says whether a transfer actually took place, and the status value from before the access. That status value feeds the microcode S flag.

The far side of the port reads and writes either word by address. It can also set or clear the status bit to show that data is ready or that space is free.

Top module: `iop_port`

## Requirements
- R1: After reset the pointer, the status bit, both words, the grant vector and all response outputs are zero.
- R2: When the port is free, the lowest-index requester with `lock_req` high is granted. Its bit in `lock_gnt` rises one cycle later, and at most one grant bit is ever high. Requests made while the port is held wait. A release from the holder frees the port one cycle later. A release from any other requester is ignored.
- R3: An access is accepted only when exactly one of `acc_ld` and `acc_st` is high and `acc_src` names the current holder. An accepted access pulses `acc_ack` one cycle later. Any other strobe pattern pulses `acc_err` one cycle later and changes neither the words, the pointer nor the status bit. The mode field is laid out as follows: bit 0 is the condition bit, bit 1 is the status side-effect bit, and bit 2 is the pointer toggle bit.
- R4: An accepted load transfers data when its condition bit is 0 or the status bit is 1. In that case, one cycle later `rd_valid` is 1 and `rd_data` equals the word selected by the pointer. Otherwise `rd_valid` and `rd_data` are 0.
- R5: An accepted load with the side-effect bit set leaves the status bit at 0, whether or not data was transferred.
- R6: An accepted store writes `acc_wdata` into the selected word when its condition bit is 0 or the status bit is 0. In that case `wr_done` pulses one cycle later. Otherwise the word is unchanged and `wr_done` stays 0.
- R7: An accepted store with the side-effect bit set leaves the status bit at 1, whether or not the word was written.
- R8: An accepted access with the toggle bit set flips the word pointer. The access itself uses the pointer value from before the flip.
- R9: In the cycle of `acc_ack`, `sts_prev` equals the status bit as it was before the access. Otherwise `sts_prev` is 0.
- R10: `ext_rdata` always shows the word selected by `ext_addr`. `ext_we` writes that word. `ext_stat_set` and `ext_stat_clr` set or clear the status bit, with set winning over clear. In the same cycle, an accepted store to the same word and an access's status side effect both take precedence over the far side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_req | input | NUM_REQ | Per-requester lock request |
| lock_rel | input | NUM_REQ | Per-requester lock release |
| lock_gnt | output | NUM_REQ | One-hot grant; shows the current holder |
| acc_ld | input | 1 | Load strobe |
| acc_st | input | 1 | Store strobe |
| acc_src | input | SRC_W | Index of the requester making the access |
| acc_mode | input | 3 | Mode: bit 0 condition, bit 1 status side effect, bit 2 pointer toggle |
| acc_wdata | input | DATA_W | Store data |
| acc_ack | output | 1 | Access accepted (one cycle after the strobe) |
| acc_err | output | 1 | Access rejected (one cycle after the strobe) |
| rd_valid | output | 1 | Load transferred data |
| rd_data | output | DATA_W | Load data, zero when no transfer took place |
| wr_done | output | 1 | Store wrote a word |
| sts_prev | output | 1 | Status value before the accepted access |
| ext_addr | input | 1 | Far-side word select |
| ext_we | input | 1 | Far-side write enable |
| ext_wdata | input | DATA_W | Far-side write data |
| ext_rdata | output | DATA_W | Far-side read data |
| ext_stat_set | input | 1 | Far side sets the status bit |
| ext_stat_clr | input | 1 | Far side clears the status bit |
| port_status | output | 1 | Current status bit |
| word_ptr | output | 1 | Current word pointer |

## Verification
The assertions assume that `acc_src` stays below NUM_REQ. They also assume that a release, when it is meant to count, comes from the holder. A stray release is allowed and must leave the lock unchanged.

The stimulus keeps `acc_src` inside the requester range at all times. The random phase deliberately mixes in accesses from non-holders, double strobes, stray releases and colliding far-side writes and status changes. This exercises the rejection and precedence rules without leaving the input domain the properties rely on.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int MODE_W = 3;

    // Mode field: bit 0 condition, bit 1 status side effect, bit 2 pointer toggle
    typedef struct packed {
        logic tog;
        logic side;
        logic cond;
    } iop_mode_t;

    // Decoded access for one cycle
    typedef struct packed {
        logic ok;
        logic err;
        logic is_ld;
        logic is_st;
        logic xfer_rd;
        logic xfer_wr;
        logic st_clr;
        logic st_set;
        logic tog;
    } iop_cmd_t;

endpackage

// File: rtl/iop_lock_arb.sv
module iop_lock_arb #(
    parameter int NUM_REQ = 4,
    parameter int SRC_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [NUM_REQ-1:0] rel_i,
    output logic               held_o,
    output logic [SRC_W-1:0]   holder_o,
    output logic [NUM_REQ-1:0] gnt_o
);

    typedef struct packed {
        logic             held;
        logic [SRC_W-1:0] holder;
    } arb_t;

    arb_t             s_d, s_q;
    logic [SRC_W-1:0] pick;
    logic             found;

    always_comb begin
        s_d   = s_q;
        pick  = '0;
        found = 1'b0;
        // Descending scan so that the lowest index is the last one written
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick  = SRC_W'(i);
                found = 1'b1;
            end
        end
        if (s_q.held) begin
            if (rel_i[s_q.holder]) begin
                s_d.held = 1'b0;
            end
        end else if (found) begin
            s_d.held   = 1'b1;
            s_d.holder = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign held_o   = s_q.held;
    assign holder_o = s_q.holder;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_gnt
        assign gnt_o[g] = s_q.held && (s_q.holder == SRC_W'(g));
    end

    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.held && !rel_i[s_q.holder]) |=> (s_q.held && $stable(s_q.holder)));

    assert_release_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.held && rel_i[s_q.holder]) |=> !s_q.held);

endmodule

// File: rtl/iop_access_dec.sv
module iop_access_dec #(
    parameter int SRC_W = 2
) (
    input  logic                ld_i,
    input  logic                st_i,
    input  logic [SRC_W-1:0]    src_i,
    input  iop_pkg::iop_mode_t  mode_i,
    input  logic                held_i,
    input  logic [SRC_W-1:0]    holder_i,
    input  logic                status_i,
    output iop_pkg::iop_cmd_t   cmd_o
);

    logic owner;
    logic single;

    always_comb begin
        owner         = held_i && (src_i == holder_i);
        single        = ld_i ^ st_i;
        cmd_o         = '0;
        cmd_o.ok      = owner && single;
        cmd_o.err     = (ld_i || st_i) && !cmd_o.ok;
        cmd_o.is_ld   = cmd_o.ok && ld_i;
        cmd_o.is_st   = cmd_o.ok && st_i;
        cmd_o.xfer_rd = cmd_o.is_ld && (!mode_i.cond || status_i);
        cmd_o.xfer_wr = cmd_o.is_st && (!mode_i.cond || !status_i);
        cmd_o.st_clr  = cmd_o.is_ld && mode_i.side;
        cmd_o.st_set  = cmd_o.is_st && mode_i.side;
        cmd_o.tog     = cmd_o.ok && mode_i.tog;
    end

endmodule

// File: rtl/iop_word_store.sv
module iop_word_store #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  iop_pkg::iop_cmd_t cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ext_addr_i,
    input  logic              ext_we_i,
    input  logic [DATA_W-1:0] ext_wdata_i,
    input  logic              ext_set_i,
    input  logic              ext_clr_i,
    output logic [DATA_W-1:0] ext_rdata_o,
    output logic              status_o,
    output logic              ptr_o,
    output logic              ack_o,
    output logic              err_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wr_done_o,
    output logic              prev_o
);

    localparam int NUM_WORDS = 2;

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
        logic                             ptr;
        logic                             status;
        logic                             ack;
        logic                             err;
        logic                             rd_valid;
        logic [DATA_W-1:0]                rd_data;
        logic                             wr_done;
        logic                             prev;
    } ws_t;

    ws_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        // Far side first; the access side overrides it below
        if (ext_we_i) begin
            s_d.words[ext_addr_i] = ext_wdata_i;
        end
        if (cmd_i.xfer_wr) begin
            s_d.words[s_q.ptr] = wdata_i;
        end

        if (ext_set_i) begin
            s_d.status = 1'b1;
        end else if (ext_clr_i) begin
            s_d.status = 1'b0;
        end
        if (cmd_i.st_clr) begin
            s_d.status = 1'b0;
        end
        if (cmd_i.st_set) begin
            s_d.status = 1'b1;
        end

        if (cmd_i.tog) begin
            s_d.ptr = ~s_q.ptr;
        end

        s_d.ack      = cmd_i.ok;
        s_d.err      = cmd_i.err;
        s_d.rd_valid = cmd_i.xfer_rd;
        s_d.rd_data  = cmd_i.xfer_rd ? s_q.words[s_q.ptr] : '0;
        s_d.wr_done  = cmd_i.xfer_wr;
        s_d.prev     = cmd_i.ok ? s_q.status : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ext_rdata_o = s_q.words[ext_addr_i];
    assign status_o    = s_q.status;
    assign ptr_o       = s_q.ptr;
    assign ack_o       = s_q.ack;
    assign err_o       = s_q.err;
    assign rd_valid_o  = s_q.rd_valid;
    assign rd_data_o   = s_q.rd_data;
    assign wr_done_o   = s_q.wr_done;
    assign prev_o      = s_q.prev;

    assert_load_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.st_clr |=> !status_o);

    assert_store_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.st_set |=> status_o);

    assert_ptr_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.tog |=> (ptr_o != $past(ptr_o)));

    assert_ptr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_i.tog |=> $stable(ptr_o));

    assert_read_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.xfer_rd |=> (rd_data_o == $past(s_q.words[s_q.ptr])));

endmodule

// File: rtl/iop_port.sv
module iop_port #(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 16,
    parameter int SRC_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] lock_req,
    input  logic [NUM_REQ-1:0] lock_rel,
    output logic [NUM_REQ-1:0] lock_gnt,
    input  logic               acc_ld,
    input  logic               acc_st,
    input  logic [SRC_W-1:0]   acc_src,
    input  logic [2:0]         acc_mode,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               acc_ack,
    output logic               acc_err,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               wr_done,
    output logic               sts_prev,
    input  logic               ext_addr,
    input  logic               ext_we,
    input  logic [DATA_W-1:0]  ext_wdata,
    output logic [DATA_W-1:0]  ext_rdata,
    input  logic               ext_stat_set,
    input  logic               ext_stat_clr,
    output logic               port_status,
    output logic               word_ptr
);

    import iop_pkg::*;

    logic             held;
    logic [SRC_W-1:0] holder;
    iop_mode_t        mode;
    iop_cmd_t         cmd;

    assign mode = iop_mode_t'(acc_mode);

    iop_lock_arb #(
        .NUM_REQ (NUM_REQ),
        .SRC_W   (SRC_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (lock_req),
        .rel_i    (lock_rel),
        .held_o   (held),
        .holder_o (holder),
        .gnt_o    (lock_gnt)
    );

    iop_access_dec #(
        .SRC_W (SRC_W)
    ) u_dec (
        .ld_i     (acc_ld),
        .st_i     (acc_st),
        .src_i    (acc_src),
        .mode_i   (mode),
        .held_i   (held),
        .holder_i (holder),
        .status_i (port_status),
        .cmd_o    (cmd)
    );

    iop_word_store #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .wdata_i     (acc_wdata),
        .ext_addr_i  (ext_addr),
        .ext_we_i    (ext_we),
        .ext_wdata_i (ext_wdata),
        .ext_set_i   (ext_stat_set),
        .ext_clr_i   (ext_stat_clr),
        .ext_rdata_o (ext_rdata),
        .status_o    (port_status),
        .ptr_o       (word_ptr),
        .ack_o       (acc_ack),
        .err_o       (acc_err),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data),
        .wr_done_o   (wr_done),
        .prev_o      (sts_prev)
    );

    assert_ack_err_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ack && acc_err));

    assert_reject_no_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_ld || acc_st) && !(held && acc_src == holder && (acc_ld ^ acc_st)))
            |=> (acc_err && $stable(word_ptr)));

    assert_gated_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_st && !acc_ld && held && acc_src == holder && acc_mode[0] && port_status)
            |=> !wr_done);

    assert_gated_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ld && !acc_st && held && acc_src == holder && acc_mode[0] && !port_status)
            |=> (!rd_valid && rd_data == '0));

    assert_prev_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> (sts_prev == $past(port_status)));

endmodule

// File: tb/iop_port_test.sv
module iop_port_test;

    localparam int NUM_REQ = 4;
    localparam int DATA_W  = 16;
    localparam int SRC_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_REQ-1:0] lock_req = '0;
    logic [NUM_REQ-1:0] lock_rel = '0;
    logic [NUM_REQ-1:0] lock_gnt;
    logic               acc_ld = 1'b0;
    logic               acc_st = 1'b0;
    logic [SRC_W-1:0]   acc_src = '0;
    logic [2:0]         acc_mode = '0;
    logic [DATA_W-1:0]  acc_wdata = '0;
    logic               acc_ack, acc_err, rd_valid, wr_done, sts_prev;
    logic [DATA_W-1:0]  rd_data, ext_rdata;
    logic               ext_addr = 1'b0;
    logic               ext_we = 1'b0;
    logic [DATA_W-1:0]  ext_wdata = '0;
    logic               ext_stat_set = 1'b0;
    logic               ext_stat_clr = 1'b0;
    logic               port_status, word_ptr;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic              m_held, m_stat, m_ptr;
    int                m_holder;
    logic [DATA_W-1:0] m_w [2];
    logic              m_ack, m_err, m_rdv, m_wr, m_prev;
    logic [DATA_W-1:0] m_rdd;
    logic [NUM_REQ-1:0] m_gnt;

    always #5 clk = ~clk;

    iop_port #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .SRC_W(SRC_W)) uut (
        .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .lock_rel(lock_rel),
        .lock_gnt(lock_gnt), .acc_ld(acc_ld), .acc_st(acc_st), .acc_src(acc_src),
        .acc_mode(acc_mode), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
        .acc_err(acc_err), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_done(wr_done), .sts_prev(sts_prev), .ext_addr(ext_addr),
        .ext_we(ext_we), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_stat_set(ext_stat_set), .ext_stat_clr(ext_stat_clr),
        .port_status(port_status), .word_ptr(word_ptr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic ok, old_stat, old_ptr;
        if (!rst_n) begin
            m_held = 0; m_holder = 0; m_stat = 0; m_ptr = 0;
            m_w[0] = '0; m_w[1] = '0;
            m_ack = 0; m_err = 0; m_rdv = 0; m_wr = 0; m_prev = 0; m_rdd = '0;
        end else begin
            old_stat = m_stat;
            old_ptr  = m_ptr;
            ok    = m_held && (int'(acc_src) == m_holder) && (acc_ld ^ acc_st);
            m_ack = ok;
            m_err = (acc_ld || acc_st) && !ok;
            m_rdv = ok && acc_ld && (!acc_mode[0] || old_stat);
            m_rdd = m_rdv ? m_w[old_ptr] : '0;
            m_wr  = ok && acc_st && (!acc_mode[0] || !old_stat);
            m_prev = ok ? old_stat : 1'b0;
            if (ext_we) m_w[ext_addr] = ext_wdata;
            if (m_wr)   m_w[old_ptr]  = acc_wdata;
            if (ext_stat_set)      m_stat = 1'b1;
            else if (ext_stat_clr) m_stat = 1'b0;
            if (ok && acc_ld && acc_mode[1]) m_stat = 1'b0;
            if (ok && acc_st && acc_mode[1]) m_stat = 1'b1;
            if (ok && acc_mode[2]) m_ptr = ~m_ptr;
            if (m_held) begin
                if (lock_rel[m_holder]) m_held = 1'b0;
            end else begin
                for (int i = NUM_REQ - 1; i >= 0; i--) begin
                    if (lock_req[i]) begin
                        m_held = 1'b1;
                        m_holder = i;
                    end
                end
            end
        end
        m_gnt = m_held ? NUM_REQ'(1 << m_holder) : '0;
    endtask

    task automatic compare();
        chk(lock_gnt == m_gnt, "R2", "lock_gnt", lock_gnt, m_gnt);
        chk(acc_err == m_err, "R3", "acc_err", acc_err, m_err);
        chk(acc_ack == m_ack, "R3", "acc_ack", acc_ack, m_ack);
        chk(rd_valid == m_rdv, "R4", "rd_valid", rd_valid, m_rdv);
        chk(rd_data == m_rdd, "R4", "rd_data", rd_data, m_rdd);
        chk(wr_done == m_wr, "R6", "wr_done", wr_done, m_wr);
        chk(port_status == m_stat, "R5_R7", "port_status", port_status, m_stat);
        chk(word_ptr == m_ptr, "R8", "word_ptr", word_ptr, m_ptr);
        chk(sts_prev == m_prev, "R9", "sts_prev", sts_prev, m_prev);
        chk(ext_rdata == m_w[ext_addr], "R10", "ext_rdata", ext_rdata, m_w[ext_addr]);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        acc_ld = 0; acc_st = 0; ext_we = 0; ext_stat_set = 0; ext_stat_clr = 0;
        lock_rel = '0;
    endtask

    task automatic access(input bit ld, input int src, input logic [2:0] mode,
                          input logic [DATA_W-1:0] wd);
        acc_ld = ld; acc_st = !ld; acc_src = SRC_W'(src);
        acc_mode = mode; acc_wdata = wd;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc(); cyc();
        // R1: reset state
        chk(lock_gnt == 0 && word_ptr == 0 && port_status == 0 && ext_rdata == 0
            && !acc_ack && !acc_err && !rd_valid && !wr_done, "R1", "reset", 0, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc();

        // R3: access without a lock is rejected
        access(1, 0, 3'b000, '0);
        chk(acc_err == 1, "R3", "unlocked load err", acc_err, 1);

        // R2: simultaneous requests, lowest wins, other waits
        lock_req = 4'b0101; cyc();
        chk(lock_gnt == 4'b0001, "R2", "grant lowest", lock_gnt, 1);
        lock_req = 4'b0100;

        // R10: far side fills both words
        ext_we = 1; ext_addr = 0; ext_wdata = 16'h1234; cyc();
        ext_we = 1; ext_addr = 1; ext_wdata = 16'hABCD; cyc();
        chk(ext_rdata == 16'hABCD, "R10", "ext write", ext_rdata, 16'hABCD);

        // R4/R8: plain load with toggle
        access(1, 0, 3'b100, '0);
        chk(rd_data == 16'h1234 && word_ptr == 1, "R4", "load+toggle", rd_data, 16'h1234);
        // R4: conditional load with status clear gives nothing
        access(1, 0, 3'b001, '0);
        chk(rd_valid == 0, "R4", "gated load", rd_valid, 0);
        // R7: store with side effect sets status
        access(0, 0, 3'b010, 16'h5555);
        chk(port_status == 1 && wr_done == 1, "R7", "store sets status", port_status, 1);
        // R6: conditional store with status set is blocked
        access(0, 0, 3'b001, 16'h7777);
        chk(wr_done == 0 && sts_prev == 1, "R6", "gated store", wr_done, 0);
        // R5: conditional load, clear, toggle
        access(1, 0, 3'b111, '0);
        chk(rd_data == 16'h5555 && port_status == 0 && word_ptr == 0, "R5",
            "load clears status", rd_data, 16'h5555);

        // R3: non-holder and double strobe rejected
        access(1, 2, 3'b100, '0);
        chk(acc_err == 1 && word_ptr == 0, "R3", "non-holder", acc_err, 1);
        acc_ld = 1; acc_st = 1; acc_src = 0; acc_mode = 3'b110; cyc();
        chk(acc_err == 1 && port_status == 0, "R3", "double strobe", acc_err, 1);

        // R10: set wins over clear; access side effect wins over far side
        ext_stat_set = 1; ext_stat_clr = 1; cyc();
        chk(port_status == 1, "R10", "set over clear", port_status, 1);
        ext_stat_set = 1; acc_ld = 1; acc_src = 0; acc_mode = 3'b010; cyc();
        chk(port_status == 0, "R10", "load side effect wins", port_status, 0);
        ext_we = 1; ext_addr = 0; ext_wdata = 16'hDEAD;
        acc_st = 1; acc_src = 0; acc_mode = 3'b000; acc_wdata = 16'hBEEF; cyc();
        ext_addr = 0; cyc();
        chk(ext_rdata == 16'hBEEF, "R10", "store wins collision", ext_rdata, 16'hBEEF);

        // R2: stray release ignored, holder release hands over
        lock_rel = 4'b0100; cyc();
        chk(lock_gnt == 4'b0001, "R2", "stray release", lock_gnt, 1);
        lock_rel = 4'b0001; cyc();
        chk(lock_gnt == 4'b0000, "R2", "released", lock_gnt, 0);
        cyc();
        chk(lock_gnt == 4'b0100, "R2", "waiter granted", lock_gnt, 4);
        lock_req = '0;
        access(1, 2, 3'b000, '0);
        chk(acc_ack == 1, "R9", "new holder access", acc_ack, 1);

        // Random mix
        for (int k = 0; k < 2000; k++) begin
            lock_req     = NUM_REQ'($urandom);
            lock_rel     = (($urandom % 8) == 0) ? NUM_REQ'($urandom) : '0;
            acc_ld       = ($urandom % 3) == 0;
            acc_st       = ($urandom % 3) == 0;
            acc_src      = (($urandom % 4) == 0) ? SRC_W'($urandom) : SRC_W'(m_holder);
            acc_mode     = 3'($urandom);
            acc_wdata    = DATA_W'($urandom);
            ext_addr     = 1'($urandom);
            ext_we       = ($urandom % 4) == 0;
            ext_wdata    = DATA_W'($urandom);
            ext_stat_set = ($urandom % 6) == 0;
            ext_stat_clr = ($urandom % 6) == 0;
            cyc();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule